// File: doc/BRIEF.md
# Lookahead-Gated Multithread Issue Selector

This block picks, every clock cycle, at most one hardware thread to launch an instruction into a long in-order pipeline. Each candidate instruction comes with a 3-bit lookahead count. The count says how many of the same thread's following instructions do not depend on it. The block keeps a short list of outstanding instructions for each thread, with a remaining-lookahead counter per entry. A thread may issue again only while every one of its outstanding entries still has independent successors left to spend. This lets a few threads keep a deep pipeline busy without any register scoreboard.

Ordinary instructions retire themselves when they leave the pipeline, through an internal delay line. Memory instructions have a much longer latency and stay outstanding until the memory system returns a completion that names the thread and the list slot. The issue output reports that slot so the memory system can return it. Among the eligible threads, the winner is chosen round-robin, starting from the thread after the one that issued last.

Top module: `mtis_issue`

## Requirements
- R1: At most one instruction issues per cycle; `issue_valid` is high only when `thr_avail[issue_tid]` is high, and `issue_tid` is below NUM_THREADS.
- R2: Each issued instruction takes a list entry whose counter is loaded with its lookahead value (`thr_look[3*t+2:3*t]` for thread t, 0 to 7); the counter drops by one on each later issue by the same thread; the thread is ineligible while any of its entries has a counter of zero.
- R3: A thread whose only outstanding entry is a non-memory instruction with lookahead 0 issues again exactly PIPE_DEPTH cycles after that instruction, and not earlier.
- R4: A single thread whose non-memory instructions all carry lookahead k issues k+1 times back to back and then waits, repeating with period PIPE_DEPTH (for k=3 and depth 21: cycles 0-3, 21-24, 42-45).
- R5: Among eligible threads the grant goes to the first one found by counting upward, with wrap-around, from the thread after the last issuer.
- R6: When no thread is eligible, `issue_valid` is low.
- R7: A thread holds at most SLOTS outstanding entries; with a full list it does not issue.
- R8: A memory instruction (`thr_mem[t]` high) is not retired by the pipeline delay line; it stays outstanding until a `mem_done` pulse carrying its thread and slot, and the thread may issue in the cycle after that pulse.
- R9: `issue_slot` gives the lowest-numbered free entry of the issuing thread's list; that entry receives the new instruction.
- R10: After reset every list is empty and the round-robin pointer sits on the last thread, so thread 0 wins first.
- R11: A thread blocked by its lookahead does not delay the other threads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thr_avail | input | NUM_THREADS | Thread has a next instruction ready |
| thr_look | input | 3*NUM_THREADS | Lookahead count of each thread's next instruction |
| thr_mem | input | NUM_THREADS | Each thread's next instruction is a memory operation |
| mem_done | input | 1 | Memory completion pulse |
| mem_done_tid | input | $clog2(NUM_THREADS) | Thread of the completing memory instruction |
| mem_done_slot | input | $clog2(SLOTS) | List slot of the completing memory instruction |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_tid | output | $clog2(NUM_THREADS) | Issuing thread |
| issue_slot | output | $clog2(SLOTS) | Slot allocated to the issued instruction |

## Verification
The assertions assume that `mem_done` only names a slot that holds an outstanding memory instruction of that thread, and that the thread inputs are steady for the whole cycle in which they are sampled. The stimulus returns memory completions only for slots it has seen issued, using the slot reported by `issue_slot`. It changes the thread inputs only on the falling clock edge. Each scenario starts from a fresh reset, so the remaining-lookahead counters of one test do not leak into the next.

// File: rtl/mtis_pkg.sv
// Shared definitions for the lookahead-gated issue selector.
// Assumes the lookahead field is fixed at three bits by the instruction format.
package mtis_pkg;
    localparam int LA_W = 3;
    typedef logic [LA_W-1:0] la_t;
endpackage

// File: rtl/mtis_slot_track.sv
// Per-thread list of outstanding instructions.
// Each busy entry holds a remaining-lookahead counter. The thread is ready
// when no busy counter is zero and a free entry exists.
// Assumes issue_en is only raised while ready is high, and that clr_mask
// only marks busy entries.
module mtis_slot_track
    import mtis_pkg::*;
#(
    parameter int SLOTS  = 8,
    parameter int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_en,
    input  la_t               issue_la,
    input  logic [SLOTS-1:0]  clr_mask,
    output logic              ready,
    output logic [SLOT_W-1:0] free_slot
);
    logic [SLOTS-1:0] busy;
    la_t              rem [SLOTS];

    // Readiness: no exhausted entry and room for one more; lowest free slot.
    always_comb begin
        ready     = !(&busy);
        free_slot = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (busy[s] && rem[s] == '0) ready = 1'b0;
        end
        for (int s = SLOTS - 1; s >= 0; s--) begin
            if (!busy[s]) free_slot = SLOT_W'(s);
        end
    end

    // Entry update: allocate on issue, age on own issue, clear on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= '0;
            for (int s = 0; s < SLOTS; s++) rem[s] <= '0;
        end else begin
            for (int s = 0; s < SLOTS; s++) begin
                if (issue_en && !busy[s] && free_slot == SLOT_W'(s)) begin
                    busy[s] <= 1'b1;
                    rem[s]  <= issue_la;
                end else begin
                    if (clr_mask[s]) busy[s] <= 1'b0;
                    if (issue_en && busy[s]) rem[s] <= rem[s] - la_t'(1);
                end
            end
        end
    end
endmodule

// File: rtl/mtis_rr_pick.sv
// Round-robin picker: the first requester after 'last', with wrap-around.
// Purely combinational; assumes last < N.
module mtis_rr_pick #(
    parameter int N = 8,
    parameter int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req,
    input  logic [W-1:0] last,
    output logic         grant_valid,
    output logic [W-1:0] grant_id
);
    // Scan N candidates starting one past the previous winner.
    always_comb begin
        grant_valid = 1'b0;
        grant_id    = last;
        for (int k = 1; k <= N; k++) begin
            int cand;
            cand = (int'(last) + k) % N;
            if (!grant_valid && req[cand]) begin
                grant_valid = 1'b1;
                grant_id    = W'(cand);
            end
        end
    end
endmodule

// File: rtl/mtis_done_pipe.sv
// Delay line carrying (thread, slot) of non-memory instructions.
// A token entered at an issue edge appears at the output DEPTH edges later.
// Assumes DEPTH >= 1.
module mtis_done_pipe #(
    parameter int DEPTH = 20,
    parameter int TW    = 3,
    parameter int SW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [TW-1:0] in_tid,
    input  logic [SW-1:0] in_slot,
    output logic          out_valid,
    output logic [TW-1:0] out_tid,
    output logic [SW-1:0] out_slot
);
    logic [DEPTH-1:0] v_q;
    logic [TW-1:0]    tid_q  [DEPTH];
    logic [SW-1:0]    slot_q [DEPTH];

    // Shift tokens one stage per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
            for (int s = 0; s < DEPTH; s++) begin
                tid_q[s]  <= '0;
                slot_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < DEPTH; s++) begin
                if (s == 0) begin
                    v_q[s]    <= in_valid;
                    tid_q[s]  <= in_tid;
                    slot_q[s] <= in_slot;
                end else begin
                    v_q[s]    <= v_q[s-1];
                    tid_q[s]  <= tid_q[s-1];
                    slot_q[s] <= slot_q[s-1];
                end
            end
        end
    end

    assign out_valid = v_q[DEPTH-1];
    assign out_tid   = tid_q[DEPTH-1];
    assign out_slot  = slot_q[DEPTH-1];
endmodule

// File: rtl/mtis_issue.sv
// Lookahead-gated multithread issue selector (top).
// Picks one eligible thread per cycle round-robin. A thread is eligible when it
// has an instruction available and its outstanding list allows another issue.
// Non-memory instructions retire PIPE_DEPTH cycles after issue; memory ones
// retire on mem_done. Assumes PIPE_DEPTH >= 2 and that mem_done names a busy
// memory entry.
module mtis_issue
    import mtis_pkg::*;
#(
    parameter int NUM_THREADS = 8,
    parameter int PIPE_DEPTH  = 21,
    parameter int SLOTS       = 8,
    localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
    localparam int SLOT_W     = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int DLY        = PIPE_DEPTH - 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_THREADS-1:0]      thr_avail,
    input  logic [NUM_THREADS*LA_W-1:0] thr_look,
    input  logic [NUM_THREADS-1:0]      thr_mem,
    input  logic                        mem_done,
    input  logic [TID_W-1:0]            mem_done_tid,
    input  logic [SLOT_W-1:0]           mem_done_slot,
    output logic                        issue_valid,
    output logic [TID_W-1:0]            issue_tid,
    output logic [SLOT_W-1:0]           issue_slot
);
    logic [NUM_THREADS-1:0] ready;
    logic [NUM_THREADS-1:0] elig;
    logic [SLOT_W-1:0]      free_slot [NUM_THREADS];
    logic [TID_W-1:0]       last_tid;
    logic                   ret_valid;
    logic [TID_W-1:0]       ret_tid;
    logic [SLOT_W-1:0]      ret_slot;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        logic [SLOTS-1:0] clr;

        // Completion mask for this thread from the delay line and memory.
        always_comb begin
            clr = '0;
            if (ret_valid && ret_tid == TID_W'(t)) clr[ret_slot] = 1'b1;
            if (mem_done && mem_done_tid == TID_W'(t)) clr[mem_done_slot] = 1'b1;
        end

        mtis_slot_track #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_track (
            .clk       (clk),
            .rst_n     (rst_n),
            .issue_en  (issue_valid && issue_tid == TID_W'(t)),
            .issue_la  (thr_look[t*LA_W +: LA_W]),
            .clr_mask  (clr),
            .ready     (ready[t]),
            .free_slot (free_slot[t])
        );
    end

    assign elig = thr_avail & ready;

    mtis_rr_pick #(.N(NUM_THREADS), .W(TID_W)) u_pick (
        .req         (elig),
        .last        (last_tid),
        .grant_valid (issue_valid),
        .grant_id    (issue_tid)
    );

    assign issue_slot = free_slot[issue_tid];

    // Round-robin pointer: remembers the last issuing thread.
    always_ff @(posedge clk) begin
        if (!rst_n)           last_tid <= TID_W'(NUM_THREADS - 1);
        else if (issue_valid) last_tid <= issue_tid;
    end

    mtis_done_pipe #(.DEPTH(DLY), .TW(TID_W), .SW(SLOT_W)) u_ret (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (issue_valid && !thr_mem[issue_tid]),
        .in_tid    (issue_tid),
        .in_slot   (issue_slot),
        .out_valid (ret_valid),
        .out_tid   (ret_tid),
        .out_slot  (ret_slot)
    );
endmodule

// File: rtl/mtis_issue_chk.sv
// Checker for mtis_issue, bound to every instance.
// Assumes mem_done targets only busy memory entries.
module mtis_issue_chk #(
    parameter int NUM_THREADS = 8,
    parameter int SLOTS       = 8,
    parameter int TID_W       = 3,
    parameter int SLOT_W      = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_THREADS-1:0]   thr_avail,
    input logic [NUM_THREADS*3-1:0] thr_look,
    input logic                     issue_valid,
    input logic [TID_W-1:0]         issue_tid,
    input logic [SLOT_W-1:0]        issue_slot
);
    logic [2:0] cur_la;
    assign cur_la = thr_look[int'(issue_tid)*3 +: 3];

    assert_avail_R1: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (thr_avail[issue_tid] && int'(issue_tid) < NUM_THREADS));

    assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_avail == '0) |-> !issue_valid);

    assert_la0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && cur_la == 3'd0) |=> !(issue_valid && issue_tid == $past(issue_tid)));

    assert_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> !(issue_valid && issue_tid == $past(issue_tid)
                          && issue_slot == $past(issue_slot)));
endmodule

bind mtis_issue mtis_issue_chk #(
    .NUM_THREADS (NUM_THREADS),
    .SLOTS       (SLOTS),
    .TID_W       (TID_W),
    .SLOT_W      (SLOT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .thr_avail   (thr_avail),
    .thr_look    (thr_look),
    .issue_valid (issue_valid),
    .issue_tid   (issue_tid),
    .issue_slot  (issue_slot)
);

// File: tb/mtis_issue_bench.sv
// Bench for mtis_issue: a vector walk for round-robin, then directed tests.
module mtis_issue_bench;
    localparam int T = 8;
    localparam int L = 21;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [T-1:0] thr_avail = '0;
    logic [T*3-1:0] thr_look = '1;
    logic [T-1:0] thr_mem = '0;
    logic         mem_done = 1'b0;
    logic [2:0]   mem_done_tid = '0;
    logic [2:0]   mem_done_slot = '0;
    logic         issue_valid;
    logic [2:0]   issue_tid;
    logic [2:0]   issue_slot;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    mtis_issue #(.NUM_THREADS(T), .PIPE_DEPTH(L), .SLOTS(8)) u_mtis_issue (
        .clk(clk), .rst_n(rst_n), .thr_avail(thr_avail), .thr_look(thr_look),
        .thr_mem(thr_mem), .mem_done(mem_done), .mem_done_tid(mem_done_tid),
        .mem_done_slot(mem_done_slot), .issue_valid(issue_valid),
        .issue_tid(issue_tid), .issue_slot(issue_slot)
    );

    // {avail mask, expected valid, expected thread}; all lookahead 7.
    localparam logic [11:0] VEC [10] = '{
        {8'hFF, 1'b1, 3'd0}, {8'hFF, 1'b1, 3'd1}, {8'h00, 1'b0, 3'd0},
        {8'h81, 1'b1, 3'd7}, {8'h81, 1'b1, 3'd0}, {8'h10, 1'b1, 3'd4},
        {8'h06, 1'b1, 3'd1}, {8'h06, 1'b1, 3'd2}, {8'h06, 1'b1, 3'd1},
        {8'hF0, 1'b1, 3'd4}
    };

    function automatic int obs();
        return issue_valid ? int'(issue_tid) : -1;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; thr_avail = '0; thr_mem = '0; thr_look = '1; mem_done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R10 idle after reset", obs(), -1);
    endtask

    task automatic run_all();
        // R5 R1 R10: round-robin vector walk from a fresh reset
        do_reset();
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            thr_avail = VEC[i][11:4];
            #1;
            check($sformatf("R5 R1 R6 vector %0d", i), obs(),
                  VEC[i][3] ? int'(VEC[i][2:0]) : -1);
        end

        // R4 R2: single thread, lookahead 3, period L
        do_reset();
        thr_look[2*3 +: 3] = 3'd3;
        for (int i = 0; i < 48; i++) begin
            @(negedge clk);
            thr_avail = 8'h04;
            #1;
            check($sformatf("R4 R2 cycle %0d", i), obs(), ((i % L) < 4) ? 2 : -1);
        end

        // R3: lookahead 0 reissues exactly L cycles later
        do_reset();
        thr_look[3*3 +: 3] = 3'd0;
        for (int i = 0; i < 45; i++) begin
            @(negedge clk);
            thr_avail = 8'h08;
            #1;
            check($sformatf("R3 cycle %0d", i), obs(), ((i % L) == 0) ? 3 : -1);
        end

        // R11 R7: blocked thread 0 does not stall thread 1; full list stalls
        do_reset();
        thr_look[0 +: 3] = 3'd0;
        thr_look[3 +: 3] = 3'd7;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            thr_avail = 8'h03;
            #1;
            check($sformatf("R11 R7 cycle %0d", i), obs(), (i == 0) ? 0 : ((i <= 8) ? 1 : -1));
        end

        // R8: memory op held until mem_done, then thread issues next cycle
        do_reset();
        thr_look[5*3 +: 3] = 3'd0;
        thr_mem = 8'h20;
        @(negedge clk);
        thr_avail = 8'h20;
        #1;
        check("R8 first issue", obs(), 5);
        check("R9 first slot", int'(issue_slot), 0);
        for (int i = 1; i < 30; i++) begin
            @(negedge clk);
            #1;
            check($sformatf("R8 held cycle %0d", i), obs(), -1);
        end
        @(negedge clk);
        mem_done = 1'b1; mem_done_tid = 3'd5; mem_done_slot = 3'd0; thr_mem = '0;
        #1;
        check("R8 pulse cycle", obs(), -1);
        @(negedge clk);
        mem_done = 1'b0;
        #1;
        check("R8 after pulse", obs(), 5);

        // R9: lowest free slot after out-of-order memory completion
        do_reset();
        thr_look[6*3 +: 3] = 3'd7;
        thr_mem = 8'h40;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            thr_avail = 8'h40;
            #1;
            check($sformatf("R9 slot %0d", i), issue_valid ? int'(issue_slot) : -1, i);
        end
        @(negedge clk);
        thr_avail = '0; mem_done = 1'b1; mem_done_tid = 3'd6; mem_done_slot = 3'd1;
        #1;
        check("R6 no request", obs(), -1);
        @(negedge clk);
        mem_done = 1'b0; thr_avail = 8'h40;
        #1;
        check("R9 reuse slot 1", issue_valid ? int'(issue_slot) : -1, 1);
        @(negedge clk);
        #1;
        check("R9 next slot 3", issue_valid ? int'(issue_slot) : -1, 3);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule